// File: doc/BRIEF.md
# Four-Wire Serial Display Command Receiver

This block is the host-facing serial port of a display controller. A master drives a serial clock, an active-low chip select, a data input and a command/data select line. The block assembles each group of eight bits into a byte, tags it as a command or as display data, and hands it to the controller core as a one-cycle strobe in the system clock domain. The core then decodes and stores the byte, which lies outside this block.

All serial inputs are oversampled in the system clock `clk_i`, which must run at least eight times faster than the serial clock. Chip select high keeps the framing logic cleared, so a transfer cut short never leaks a byte. The active-low asynchronous reset `rst_ni` doubles as the external reset pin and aborts any transfer in progress. For readback the core raises `rb_en_i` and offers a byte on `rb_byte_i`. The block shifts that byte out most significant bit first, changing the output after each falling serial clock edge. The output enable is low at all other times, so the output pad can share a wire with the data input.

Top module: `disp_cmd_rx`

## Requirements
- R1: While `csn_i` is high, `sclk_i` edges produce no strobe, `sdout_oe_o` stays low and the bit position returns to the start of a byte.
- R2: `sdin_i` is taken on each rising `sclk_i` edge, and the first bit of a byte lands in bit 7 of `byte_o` (most significant bit first).
- R3: `dc_i` is taken only on the eighth rising edge of a byte. Low gives `byte_is_data_o` = 0 (command), high gives 1 (display data). Its level at other edges has no effect.
- R4: With `csn_i` held low, the rising edge after the eighth is bit 7 of a new byte, so bytes may follow back to back.
- R5: `rst_ni` low aborts the transfer in progress, delivers no byte from it and clears `byte_o`, `byte_is_data_o`, `byte_vld_o` and `sdout_oe_o`. If `csn_i` is low when reset ends, the next eight rising edges form a byte.
- R6: Each complete byte gives exactly one `byte_vld_o` pulse one `clk_i` cycle wide. `byte_o` and `byte_is_data_o` keep their value until the next pulse.
- R7: If `csn_i` rises before the eighth edge, the partial byte is dropped with no strobe, and the next transfer starts at bit 7.
- R8: If `rb_en_i` is high when a byte starts, `rb_byte_i` is driven on `sdout_o` most significant bit first with `sdout_oe_o` high. Each new bit appears after a falling `sclk_i` edge. If `rb_en_i` is low, `sdout_oe_o` stays low for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; samples all serial inputs |
| rst_ni | input | 1 | Active-low asynchronous reset; aborts transfers |
| csn_i | input | 1 | Active-low chip select from the master |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| sdin_i | input | 1 | Serial data in |
| dc_i | input | 1 | Command (0) / data (1) select |
| rb_en_i | input | 1 | Core requests readback of `rb_byte_i` |
| rb_byte_i | input | 8 | Status or identification byte to shift out |
| byte_o | output | 8 | Last received byte |
| byte_is_data_o | output | 1 | 1 if the last byte was display data |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| sdout_o | output | 1 | Serial readback data |
| sdout_oe_o | output | 1 | Enable for the tri-state readback pad |

## Verification
A table of transfers is sent with all-ones, all-zeros, single-bit-at-either-end and mixed byte values. These patterns separate bit ordering errors from stuck or shifted bits in both the receive and the readback paths. The command/data line is driven to the opposite level during the first seven bits, so sampling it at any edge but the eighth shows up. Directed cases cover back-to-back bytes with a readback byte that changes between them, a transfer cut off by chip select, clock edges with chip select high, and a reset pulse in the middle of a byte with chip select kept low.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dspi_rx.sv
module dspi_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              sdin_i,
  input  logic              dc_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              is_data_o,
  output logic              vld_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      byte_o    <= '0;
      is_data_o <= 1'b0;
      vld_o     <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!cs_act_i) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (rise_i) begin
        sh_q <= {sh_q[DATA_W-3:0], sdin_i};
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          byte_o    <= {sh_q, sdin_i};
          is_data_o <= dc_i;  // select line only matters here
          vld_o     <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dspi_tx.sv
module dspi_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              cs_start_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              rb_en_i,
  input  logic [DATA_W-1:0] rb_byte_i,
  output logic              sdout_o,
  output logic              oe_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (!cs_act_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (cs_start_i) begin
      cnt_q <= '0;
      act_q <= rb_en_i;
      sh_q  <= rb_en_i ? rb_byte_i : '0;
    end else if (rise_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end else if (fall_i) begin
      if (cnt_q == '0) begin
        // byte boundary: reload for the next byte
        act_q <= rb_en_i;
        sh_q  <= rb_en_i ? rb_byte_i : '0;
      end else begin
        sh_q <= {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdout_o = sh_q[DATA_W-1];
  assign oe_o    = act_q;
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx #(
  parameter int unsigned DATA_W     = dspi_pkg::BYTE_W,
  parameter int unsigned SYNC_DEPTH = dspi_pkg::SYNC_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              dc_i,
  input  logic              rb_en_i,
  input  logic [DATA_W-1:0] rb_byte_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_is_data_o,
  output logic              byte_vld_o,
  output logic              sdout_o,
  output logic              sdout_oe_o
);
  logic [3:0] raw, syn;
  logic       csn_s, sclk_s, sdin_s, dc_s;
  logic       sclk_q, cs_act, cs_act_q;
  logic       sclk_rise, sclk_fall, cs_start;

  assign raw = {csn_i, sclk_i, sdin_i, dc_i};

  dspi_sync #(
    .W       (4),
    .STAGES  (SYNC_DEPTH),
    .RST_VAL (4'b1000)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (syn)
  );

  assign {csn_s, sclk_s, sdin_s, dc_s} = syn;
  assign cs_act = ~csn_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      cs_act_q <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      cs_act_q <= cs_act;
    end
  end

  assign sclk_rise = cs_act & sclk_s & ~sclk_q;
  assign sclk_fall = cs_act & ~sclk_s & sclk_q;
  assign cs_start  = cs_act & ~cs_act_q;

  dspi_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_act_i  (cs_act),
    .rise_i    (sclk_rise),
    .sdin_i    (sdin_s),
    .dc_i      (dc_s),
    .byte_o    (byte_o),
    .is_data_o (byte_is_data_o),
    .vld_o     (byte_vld_o)
  );

  dspi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .cs_start_i (cs_start),
    .rise_i     (sclk_rise),
    .fall_i     (sclk_fall),
    .rb_en_i    (rb_en_i),
    .rb_byte_i  (rb_byte_i),
    .sdout_o    (sdout_o),
    .oe_o       (sdout_oe_o)
  );
endmodule

// File: rtl/disp_cmd_rx_chk.sv
module disp_cmd_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act,
  input logic              sclk_fall,
  input logic [DATA_W-1:0] byte_o,
  input logic              byte_vld_o,
  input logic              sdout_o,
  input logic              sdout_oe_o
);
  p_idle_no_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !byte_vld_o);

  p_idle_no_drive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !sdout_oe_o);

  p_strobe_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  p_byte_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> $stable(byte_o));

  p_shift_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdout_oe_o && $past(sdout_oe_o) && (sdout_o != $past(sdout_o)))
      |-> $past(sclk_fall));
endmodule

bind disp_cmd_rx disp_cmd_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_act     (cs_act),
  .sclk_fall  (sclk_fall),
  .byte_o     (byte_o),
  .byte_vld_o (byte_vld_o),
  .sdout_o    (sdout_o),
  .sdout_oe_o (sdout_oe_o)
);

// File: tb/disp_cmd_rx_bench.sv
module disp_cmd_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;       // clk cycles per sclk half period
  localparam int WD_LIMIT   = 100000;
  localparam int NVEC       = 6;
  // {byte, dc, rb_en, rb_byte}
  localparam logic [17:0] VECS [NVEC] = '{
    {8'hA5, 1'b0, 1'b1, 8'h3C},
    {8'h00, 1'b1, 1'b0, 8'h00},
    {8'hFF, 1'b0, 1'b1, 8'h81},
    {8'h01, 1'b1, 1'b1, 8'h80},
    {8'h80, 1'b0, 1'b0, 8'h00},
    {8'h6E, 1'b1, 1'b1, 8'hFF}
  };

  logic       clk = 1'b0, rst_ni = 1'b0, csn = 1'b1, sclk = 1'b0;
  logic       sdin = 1'b0, dc = 1'b0, rb_en = 1'b0;
  logic [7:0] rb_byte = 8'h00, rb_got = 8'h00;
  logic [7:0] byte_o;
  logic       byte_is_data_o, byte_vld_o, sdout_o, sdout_oe_o;

  int n_chk = 0, n_fail = 0, n_strb = 0;
  logic [7:0] last_b = 8'h00, prev_b = 8'h00;
  logic       last_dc = 1'b0, prev_dc = 1'b0;
  bit         oe_seen = 1'b0;

  disp_cmd_rx u_disp_cmd_rx (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .csn_i          (csn),
    .sclk_i         (sclk),
    .sdin_i         (sdin),
    .dc_i           (dc),
    .rb_en_i        (rb_en),
    .rb_byte_i      (rb_byte),
    .byte_o         (byte_o),
    .byte_is_data_o (byte_is_data_o),
    .byte_vld_o     (byte_vld_o),
    .sdout_o        (sdout_o),
    .sdout_oe_o     (sdout_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (byte_vld_o) begin
      n_strb  = n_strb + 1;
      prev_b  = last_b;   prev_dc = last_dc;
      last_b  = byte_o;   last_dc = byte_is_data_o;
    end
    if (sdout_oe_o) oe_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nb bits of b from bit 7 down; dc = dce before the eighth edge, dc8 on it
  task automatic send_bits(input logic [7:0] b, input int nb, input logic dc8, input logic dce);
    for (int i = 7; i > 7 - nb; i--) begin
      sdin = b[i];
      dc   = (i == 0) ? dc8 : dce;
      clk_n(HALF);
      rb_got[i] = sdout_o;
      sclk = 1'b1;
      clk_n(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", WD_LIMIT);
    summary();
    $finish;
  end

  initial begin
    int s0;
    clk_n(4);
    // reset state (R5)
    chk(byte_o == 8'h00, "R5 reset byte", byte_o, 0);
    chk(!byte_vld_o && !byte_is_data_o, "R5 reset strobe/flag", byte_vld_o, 0);
    chk(!sdout_oe_o, "R5 reset oe", sdout_oe_o, 0);
    rst_ni = 1'b1;
    clk_n(6);

    // table walk: R2 R3 R6 R8
    foreach (VECS[k]) begin
      s0 = n_strb;
      rb_en = VECS[k][8]; rb_byte = VECS[k][7:0];
      oe_seen = 1'b0;
      csn = 1'b0; clk_n(6);
      send_bits(VECS[k][17:10], 8, VECS[k][9], ~VECS[k][9]);
      clk_n(6); csn = 1'b1; clk_n(12);
      chk(n_strb == s0 + 1, "R6 one strobe per byte", n_strb - s0, 1);
      chk(last_b == VECS[k][17:10], "R2 byte msb first", last_b, VECS[k][17:10]);
      chk(last_dc == VECS[k][9], "R3 dc on eighth edge", last_dc, VECS[k][9]);
      if (VECS[k][8])
        chk(rb_got == VECS[k][7:0], "R8 readback byte", rb_got, VECS[k][7:0]);
      else
        chk(!oe_seen, "R8 no drive without request", oe_seen, 0);
      chk(!sdout_oe_o, "R1 oe low when idle", sdout_oe_o, 0);
    end

    // R4: back to back, readback byte changes between bytes
    s0 = n_strb; rb_en = 1'b1; rb_byte = 8'h3C;
    csn = 1'b0; clk_n(6);
    send_bits(8'hA5, 8, 1'b0, 1'b1);
    chk(rb_got == 8'h3C, "R8 first readback", rb_got, 8'h3C);
    rb_byte = 8'hC3;
    clk_n(2);
    send_bits(8'h5A, 8, 1'b1, 1'b0);
    chk(rb_got == 8'hC3, "R8 reload at byte end", rb_got, 8'hC3);
    clk_n(6); csn = 1'b1; clk_n(12);
    chk(n_strb == s0 + 2, "R4 two strobes", n_strb - s0, 2);
    chk(prev_b == 8'hA5 && prev_dc == 1'b0, "R4 first byte", {prev_dc, prev_b}, 9'h0A5);
    chk(last_b == 8'h5A && last_dc == 1'b1, "R4 second byte", {last_dc, last_b}, 9'h15A);

    // R1: clock toggles with chip select high
    s0 = n_strb; rb_en = 1'b1; oe_seen = 1'b0;
    send_bits(8'hFF, 8, 1'b1, 1'b1);
    clk_n(12);
    chk(n_strb == s0, "R1 no strobe while deselected", n_strb - s0, 0);
    chk(!oe_seen, "R1 no drive while deselected", oe_seen, 0);

    // R7: partial byte then a full one
    s0 = n_strb; rb_en = 1'b0;
    csn = 1'b0; clk_n(6);
    send_bits(8'hFF, 5, 1'b0, 1'b0);
    clk_n(6); csn = 1'b1; clk_n(12);
    chk(n_strb == s0, "R7 partial byte dropped", n_strb - s0, 0);
    csn = 1'b0; clk_n(6);
    send_bits(8'h81, 8, 1'b1, 1'b0);
    clk_n(6); csn = 1'b1; clk_n(12);
    chk(n_strb == s0 + 1 && last_b == 8'h81, "R7 restart at bit 7", last_b, 8'h81);

    // R5: reset pulse mid-byte, chip select kept low
    s0 = n_strb; rb_en = 1'b1; rb_byte = 8'hF0;
    csn = 1'b0; clk_n(6);
    send_bits(8'hF0, 4, 1'b1, 1'b1);
    chk(sdout_oe_o, "R8 driving before reset", sdout_oe_o, 1);
    rst_ni = 1'b0; clk_n(3);
    chk(byte_o == 8'h00 && !byte_is_data_o, "R5 outputs cleared", byte_o, 0);
    chk(!sdout_oe_o, "R5 oe cleared", sdout_oe_o, 0);
    rst_ni = 1'b1; clk_n(6);
    chk(n_strb == s0, "R5 aborted byte not delivered", n_strb - s0, 0);
    send_bits(8'h3C, 8, 1'b0, 1'b1);
    clk_n(6); csn = 1'b1; clk_n(12);
    chk(n_strb == s0 + 1, "R5 ready after reset", n_strb - s0, 1);
    chk(last_b == 8'h3C && last_dc == 1'b0, "R5 byte after reset", last_b, 8'h3C);

    summary();
    $finish;
  end
endmodule